// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits between a CPU write/read port and an embedded flash module. It watches bus writes for protected multi-cycle unlock-and-command sequences. It steers the module between array read mode, a one-shot status read, burst word loading, burst programming and sector erase. The memory array, the burst buffer and the program/erase timers are separate blocks. This decoder drives them with one-cycle start and load pulses and hears back from them through done pulses.

A status word holds the busy summary, the operation bits, the burst-loaded bit, two sticky error flags and a per-sector erased flag. A sequence that breaks off at any step is discarded: the decoder returns to read mode and raises the sequence-error flag. While a program or erase runs, only the status-read command is honoured. Control software can therefore poll for completion, but it cannot disturb the running operation.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset the status word reads 0000h, reads return array data, and no start, load or erase pulse is driven.
- R2: Command writes compare only data bits 7:0; bits 15:8 of a command write have no effect on decoding.
- R3: F0h or F5h written to AAAAh clears the sequence-error flag (bit 6) and the burst-error flag (bit 7). F0h also discards a loaded burst, clearing bit 3.
- R4: FAh written to AAAAh makes the next read return the status word instead of array data. Later reads return array data again. The layout is bit0 busy, bit1 programming, bit2 erasing, bit3 burst loaded, bit6 sequence error, bit7 burst error, bit15 sector erased; bits 4, 5 and 14:8 read 0.
- R5: 50h written to AAAAh makes the next write, at any address, the first burst word. One cycle later buf_wr_o and buf_first_o pulse with that word, and bit 3 sets. While bit 3 is set, each write to A0F2h loads one further word, with buf_first_o low.
- R6: AAh@AAAAh, 55h@5554h, A0h@AAAAh, then a data word at any address: one cycle later prog_start_o pulses with prog_addr_o equal to that address, and buf_wr_o carries the word. Bits 0 and 1 set and bit 3 clears. If no burst was loaded, bit 7 sets.
- R7: AAh@AAAAh, 55h@5554h, 80h@AAAAh, AAh@5554h, 55h@AAAAh, then 30h at any address: one cycle later erase_start_o pulses with erase_sector_o equal to address bits 15:14 of the last write. Bits 0 and 2 set.
- R8: A write with the wrong address or data at any step of a sequence, or an unknown command, sets bit 6 and returns to read mode. It clears bit 3 and produces no start pulse.
- R9: While bit 0 is set, every write except FAh@AAAAh is ignored, including F0h and F5h. Bit 1 clears only on prog_done_i and bit 2 only on erase_done_i, or both on reset.
- R10: Bit 15 shows the erased flag of the sector given by rd_sec_i. A sector's flag sets on erase_done_i for that sector and clears when a program starts in that sector. All flags are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | CPU write strobe |
| wr_addr_i | input | 16 | CPU write address offset |
| wr_data_i | input | 16 | CPU write data |
| rd_en_i | input | 1 | CPU read strobe |
| rd_sec_i | input | 2 | Sector bits (address 15:14) of the CPU read |
| arr_rd_data_i | input | 16 | Word read from the array |
| rd_data_o | output | 16 | Read data returned to the CPU |
| buf_wr_o | output | 1 | Load one word into the burst buffer |
| buf_first_o | output | 1 | Loaded word is the first of a burst |
| buf_data_o | output | 16 | Word for the burst buffer |
| prog_start_o | output | 1 | Start programming the burst |
| prog_addr_o | output | 16 | Target address of the burst program |
| prog_done_i | input | 1 | Program timer finished |
| erase_start_o | output | 1 | Start erasing a sector |
| erase_sector_o | output | 2 | Sector to erase |
| erase_done_i | input | 1 | Erase timer finished |

## Verification
Status bits and mode changes take effect at the clock edge that captures a write. The buffer, program and erase pulses are registered, so they appear in the cycle after that write. The read data is combinational and reflects the present mode in the cycle of the read. The bench drives each write or read for one full cycle starting at a falling edge. It samples pulses and the read word at the next falling edge, or one nanosecond into the read cycle. Pulse counters sample at rising edges and are compared only after an idle cycle.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam logic [15:0] UNLOCK_A      = 16'hAAAA;
  localparam logic [15:0] UNLOCK_B      = 16'h5554;
  localparam logic [15:0] BURST_LD_ADDR = 16'hA0F2;

  localparam logic [7:0] OP_RESET  = 8'hF0;
  localparam logic [7:0] OP_CLEAR  = 8'hF5;
  localparam logic [7:0] OP_STATUS = 8'hFA;
  localparam logic [7:0] OP_BURST  = 8'h50;
  localparam logic [7:0] OP_UNLK1  = 8'hAA;
  localparam logic [7:0] OP_UNLK2  = 8'h55;
  localparam logic [7:0] OP_STORE  = 8'hA0;
  localparam logic [7:0] OP_ERASE  = 8'h80;
  localparam logic [7:0] OP_SECT   = 8'h30;

  typedef enum logic [3:0] {
    ST_READ, ST_STAT, ST_BFIRST, ST_U1, ST_U2, ST_STORE, ST_E3, ST_E4, ST_E5
  } seq_state_e;
endpackage

// File: rtl/fcd_seq.sv
module fcd_seq
  import flash_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned SEC_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic              busy_i,
  output logic              stat_mode_o,
  output logic              brst_o,
  output logic              ev_sqer_o,
  output logic              ev_clr_o,
  output logic              ev_buer_o,
  output logic              ev_prog_o,
  output logic [SEC_W-1:0]  ev_prog_sec_o,
  output logic              ev_erase_o,
  output logic [SEC_W-1:0]  ev_erase_sec_o,
  output logic              buf_wr_o,
  output logic              buf_first_o,
  output logic [DATA_W-1:0] buf_data_o,
  output logic              prog_start_o,
  output logic [ADDR_W-1:0] prog_addr_o,
  output logic              erase_start_o,
  output logic [SEC_W-1:0]  erase_sector_o
);
  seq_state_e state_q, state_d;
  logic brst_q, brst_d;
  logic ld, ld_first, abort;
  logic at_a, at_b, at_ld;
  logic [7:0] lo;

  logic              buf_wr_q, buf_first_q, prog_start_q, erase_start_q;
  logic [DATA_W-1:0] buf_data_q;
  logic [ADDR_W-1:0] prog_addr_q;
  logic [SEC_W-1:0]  erase_sec_q;

  assign lo    = wr_data_i[7:0];
  assign at_a  = wr_addr_i == ADDR_W'(UNLOCK_A);
  assign at_b  = wr_addr_i == ADDR_W'(UNLOCK_B);
  assign at_ld = wr_addr_i == ADDR_W'(BURST_LD_ADDR);

  always_comb begin
    state_d    = state_q;
    brst_d     = brst_q;
    ev_clr_o   = 1'b0;
    ev_buer_o  = 1'b0;
    ev_prog_o  = 1'b0;
    ev_erase_o = 1'b0;
    ld         = 1'b0;
    ld_first   = 1'b0;
    abort      = 1'b0;
    if (rd_en_i && state_q == ST_STAT) state_d = ST_READ;
    if (wr_en_i) begin
      if (busy_i) begin
        // only status polling is honoured while an operation runs
        if (at_a && lo == OP_STATUS) state_d = ST_STAT;
      end else begin
        unique case (state_q)
          ST_READ, ST_STAT: begin
            if (brst_q && at_ld) begin
              ld = 1'b1; state_d = ST_READ;
            end else if (at_a && lo == OP_RESET) begin
              ev_clr_o = 1'b1; brst_d = 1'b0; state_d = ST_READ;
            end else if (at_a && lo == OP_CLEAR) begin
              ev_clr_o = 1'b1; state_d = ST_READ;
            end else if (at_a && lo == OP_STATUS) state_d = ST_STAT;
            else if (at_a && lo == OP_BURST)      state_d = ST_BFIRST;
            else if (at_a && lo == OP_UNLK1)      state_d = ST_U1;
            else abort = 1'b1;
          end
          ST_BFIRST: begin
            ld = 1'b1; ld_first = 1'b1; brst_d = 1'b1; state_d = ST_READ;
          end
          ST_U1: if (at_b && lo == OP_UNLK2) state_d = ST_U2; else abort = 1'b1;
          ST_U2: begin
            if (at_a && lo == OP_STORE)      state_d = ST_STORE;
            else if (at_a && lo == OP_ERASE) state_d = ST_E3;
            else abort = 1'b1;
          end
          ST_STORE: begin
            ld = 1'b1; ev_prog_o = 1'b1; ev_buer_o = !brst_q;
            brst_d = 1'b0; state_d = ST_READ;
          end
          ST_E3: if (at_b && lo == OP_UNLK1) state_d = ST_E4; else abort = 1'b1;
          ST_E4: if (at_a && lo == OP_UNLK2) state_d = ST_E5; else abort = 1'b1;
          ST_E5: begin
            if (lo == OP_SECT) begin
              ev_erase_o = 1'b1; state_d = ST_READ;
            end else abort = 1'b1;
          end
          default: abort = 1'b1;
        endcase
      end
    end
    if (abort) begin
      brst_d  = 1'b0;
      state_d = ST_READ;
    end
  end

  assign ev_sqer_o      = abort;
  assign ev_prog_sec_o  = wr_addr_i[ADDR_W-1 -: SEC_W];
  assign ev_erase_sec_o = wr_addr_i[ADDR_W-1 -: SEC_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= ST_READ;
      brst_q        <= 1'b0;
      buf_wr_q      <= 1'b0;
      buf_first_q   <= 1'b0;
      buf_data_q    <= '0;
      prog_start_q  <= 1'b0;
      prog_addr_q   <= '0;
      erase_start_q <= 1'b0;
      erase_sec_q   <= '0;
    end else begin
      state_q       <= state_d;
      brst_q        <= brst_d;
      buf_wr_q      <= ld;
      buf_first_q   <= ld_first;
      prog_start_q  <= ev_prog_o;
      erase_start_q <= ev_erase_o;
      if (ld)         buf_data_q  <= wr_data_i;
      if (ev_prog_o)  prog_addr_q <= wr_addr_i;
      if (ev_erase_o) erase_sec_q <= ev_erase_sec_o;
    end
  end

  assign stat_mode_o    = state_q == ST_STAT;
  assign brst_o         = brst_q;
  assign buf_wr_o       = buf_wr_q;
  assign buf_first_o    = buf_first_q;
  assign buf_data_o     = buf_data_q;
  assign prog_start_o   = prog_start_q;
  assign prog_addr_o    = prog_addr_q;
  assign erase_start_o  = erase_start_q;
  assign erase_sector_o = erase_sec_q;

  // R6 R7
  start_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({prog_start_q, erase_start_q}));
  // R8
  abort_no_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort |=> !prog_start_q && !erase_start_q && !brst_q);
  // R4
  stat_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STAT && rd_en_i && !wr_en_i) |=> state_q == ST_READ);
  // R9
  busy_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && wr_en_i) |=> !prog_start_q && !erase_start_q && !buf_wr_q);
endmodule

// File: rtl/fcd_status.sv
module fcd_status #(
  parameter int unsigned NUM_SECTORS = 4,
  parameter int unsigned SEC_W       = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ev_sqer_i,
  input  logic             ev_clr_i,
  input  logic             ev_buer_i,
  input  logic             ev_prog_i,
  input  logic [SEC_W-1:0] ev_prog_sec_i,
  input  logic             ev_erase_i,
  input  logic [SEC_W-1:0] ev_erase_sec_i,
  input  logic             prog_done_i,
  input  logic             erase_done_i,
  input  logic             brst_i,
  input  logic [SEC_W-1:0] rd_sec_i,
  output logic             busy_o,
  output logic [15:0]      status_o
);
  logic prg_q, ers_q, sqer_q, buer_q;
  logic [SEC_W-1:0] ers_sec_q;
  logic erased_q [NUM_SECTORS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prg_q     <= 1'b0;
      ers_q     <= 1'b0;
      ers_sec_q <= '0;
      sqer_q    <= 1'b0;
      buer_q    <= 1'b0;
    end else begin
      if (ev_prog_i)        prg_q <= 1'b1;
      else if (prog_done_i) prg_q <= 1'b0;
      if (ev_erase_i) begin
        ers_q     <= 1'b1;
        ers_sec_q <= ev_erase_sec_i;
      end else if (erase_done_i) ers_q <= 1'b0;
      if (ev_clr_i) begin
        sqer_q <= 1'b0;
        buer_q <= 1'b0;
      end else begin
        if (ev_sqer_i) sqer_q <= 1'b1;
        if (ev_buer_i) buer_q <= 1'b1;
      end
    end
  end

  for (genvar g = 0; g < NUM_SECTORS; g++) begin : g_sec
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) erased_q[g] <= 1'b0;
      else if (ev_prog_i && ev_prog_sec_i == SEC_W'(g)) erased_q[g] <= 1'b0;
      else if (ers_q && erase_done_i && ers_sec_q == SEC_W'(g)) erased_q[g] <= 1'b1;
    end
  end

  assign busy_o   = prg_q | ers_q;
  assign status_o = {erased_q[rd_sec_i], 7'b0, buer_q, sqer_q, 2'b00,
                     brst_i, ers_q, prg_q, busy_o};

  // R9
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !prog_done_i && !erase_done_i) |=> busy_o);
  // R6
  prog_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_prog_i |=> prg_q && busy_o);
  // R3
  clr_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_clr_i |=> !sqer_q && !buer_q);
  // R10
  erased_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_prog_i |=> !erased_q[$past(ev_prog_sec_i)]);
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned NUM_SECTORS = 4,
  localparam int unsigned SEC_W      = (NUM_SECTORS > 2) ? $clog2(NUM_SECTORS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic [SEC_W-1:0]  rd_sec_i,
  input  logic [DATA_W-1:0] arr_rd_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              buf_wr_o,
  output logic              buf_first_o,
  output logic [DATA_W-1:0] buf_data_o,
  output logic              prog_start_o,
  output logic [ADDR_W-1:0] prog_addr_o,
  input  logic              prog_done_i,
  output logic              erase_start_o,
  output logic [SEC_W-1:0]  erase_sector_o,
  input  logic              erase_done_i
);
  logic busy, stat_mode, brst;
  logic ev_sqer, ev_clr, ev_buer, ev_prog, ev_erase;
  logic [SEC_W-1:0] ev_prog_sec, ev_erase_sec;
  logic [15:0] status;

  fcd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEC_W(SEC_W)) u_seq (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .rd_en_i,
    .busy_i         (busy),
    .stat_mode_o    (stat_mode),
    .brst_o         (brst),
    .ev_sqer_o      (ev_sqer),
    .ev_clr_o       (ev_clr),
    .ev_buer_o      (ev_buer),
    .ev_prog_o      (ev_prog),
    .ev_prog_sec_o  (ev_prog_sec),
    .ev_erase_o     (ev_erase),
    .ev_erase_sec_o (ev_erase_sec),
    .buf_wr_o, .buf_first_o, .buf_data_o,
    .prog_start_o, .prog_addr_o,
    .erase_start_o, .erase_sector_o
  );

  fcd_status #(.NUM_SECTORS(NUM_SECTORS), .SEC_W(SEC_W)) u_status (
    .clk_i, .rst_ni,
    .ev_sqer_i      (ev_sqer),
    .ev_clr_i       (ev_clr),
    .ev_buer_i      (ev_buer),
    .ev_prog_i      (ev_prog),
    .ev_prog_sec_i  (ev_prog_sec),
    .ev_erase_i     (ev_erase),
    .ev_erase_sec_i (ev_erase_sec),
    .prog_done_i, .erase_done_i,
    .brst_i         (brst),
    .rd_sec_i,
    .busy_o         (busy),
    .status_o       (status)
  );

  assign rd_data_o = stat_mode ? DATA_W'(status) : arr_rd_data_i;

  // R1 R4
  rd_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !stat_mode) |-> rd_data_o == arr_rd_data_i);
endmodule

// File: tb/flash_cmd_decoder_tb.sv
`timescale 1ns/1ps
module flash_cmd_decoder_tb;
  localparam logic [15:0] ARR = 16'h3C00;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, prog_done = 1'b0, erase_done = 1'b0;
  logic [15:0] wr_addr = '0, wr_data = '0;
  logic [1:0] rd_sec = '0;
  logic [15:0] rd_data, buf_data, prog_addr;
  logic buf_wr, buf_first, prog_start, erase_start;
  logic [1:0] erase_sec;
  int n_chk = 0, n_fail = 0, n_erase = 0, n_prog = 0;

  always #4 clk = ~clk;

  flash_cmd_decoder u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_en_i(rd_en), .rd_sec_i(rd_sec),
    .arr_rd_data_i(ARR), .rd_data_o(rd_data), .buf_wr_o(buf_wr),
    .buf_first_o(buf_first), .buf_data_o(buf_data), .prog_start_o(prog_start),
    .prog_addr_o(prog_addr), .prog_done_i(prog_done), .erase_start_o(erase_start),
    .erase_sector_o(erase_sec), .erase_done_i(erase_done)
  );

  always @(posedge clk) begin
    if (erase_start) n_erase++;
    if (prog_start)  n_prog++;
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [15:0] q);
    @(negedge clk); rd_en = 1'b1; rd_sec = s; #1 q = rd_data;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic get_stat(input logic [1:0] s, output logic [15:0] q);
    wr(16'hAAAA, 16'h00FA);
    rd(s, q);
  endtask

  task automatic pulse_done(input bit erase);
    @(negedge clk); if (erase) erase_done = 1'b1; else prog_done = 1'b1;
    @(negedge clk); erase_done = 1'b0; prog_done = 1'b0;
  endtask

  task automatic store(input logic [15:0] a, input logic [15:0] d);
    wr(16'hAAAA, 16'h00AA); wr(16'h5554, 16'h0055); wr(16'hAAAA, 16'h00A0); wr(a, d);
  endtask

  task automatic erase_seq(input logic [15:0] a);
    wr(16'hAAAA, 16'h00AA); wr(16'h5554, 16'h0055); wr(16'hAAAA, 16'h0080);
    wr(16'h5554, 16'h00AA); wr(16'hAAAA, 16'h0055); wr(a, 16'hFF30);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [15:0] q;
    int e0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    chk("R1 pulses", {13'b0, buf_wr, prog_start, erase_start}, 16'h0000);
    rd(2'd0, q); chk("R1 R4 array read", q, ARR);
    get_stat(2'd0, q); chk("R1 status", q, 16'h0000);
    rd(2'd0, q); chk("R4 back to array", q, ARR);

    // R2 R8 R3 sweep of every low command byte at AAAAh, upper byte varied
    for (int c = 0; c < 256; c++) begin
      logic sq, bl;
      wr(16'hAAAA, 16'h00F0);
      wr(16'hAAAA, {8'(c) ^ 8'h5A, 8'(c)});
      wr(16'hAAAA, 16'h00FA);
      get_stat(2'd0, q);
      bl = (c == 8'h50);
      sq = !(c == 8'hF0 || c == 8'hF5 || c == 8'hFA || c == 8'h50);
      chk($sformatf("R2 R8 sweep code %02h", c), q, {8'h00, 1'b0, sq, 2'b00, bl, 3'b000});
    end

    // R3 clear-status clears SQER; reset-to-read discards burst
    wr(16'h1234, 16'h0000);
    wr(16'hAAAA, 16'h77F5);
    get_stat(2'd0, q); chk("R3 clear status", q, 16'h0000);
    wr(16'hAAAA, 16'h0050); wr(16'h0000, 16'h1111);
    wr(16'hAAAA, 16'h00F0);
    get_stat(2'd0, q); chk("R3 reset discards burst", q, 16'h0000);

    // R5 burst load
    wr(16'hAAAA, 16'h0050);
    wr(16'h1234, 16'hD000);
    chk("R5 first load", {buf_wr, buf_first, 14'b0}, 16'hC000);
    chk("R5 first data", buf_data, 16'hD000);
    for (int k = 1; k < 4; k++) begin
      wr(16'hA0F2, 16'hD000 + 16'(k));
      chk("R5 next load", {buf_wr, buf_first, 14'b0}, 16'h8000);
      chk("R5 next data", buf_data, 16'hD000 + 16'(k));
    end
    get_stat(2'd0, q); chk("R5 brst bit", q, 16'h0008);

    // R6 store burst
    store(16'h4040, 16'hBEEF);
    chk("R6 prog start", {15'b0, prog_start}, 16'h0001);
    chk("R6 prog addr", prog_addr, 16'h4040);
    chk("R6 last word", buf_data, 16'hBEEF);
    get_stat(2'd1, q); chk("R6 busy prg", q, 16'h0003);

    // R9 writes ignored while busy
    wr(16'hAAAA, 16'h00F5); wr(16'hAAAA, 16'h00F0);
    wr(16'hAAAA, 16'h0050); wr(16'h1111, 16'h2222);
    chk("R9 no load while busy", {15'b0, buf_wr}, 16'h0000);
    wr(16'h0F0F, 16'h0000);
    get_stat(2'd1, q); chk("R9 busy kept", q, 16'h0003);
    pulse_done(1'b0);
    get_stat(2'd1, q); chk("R9 prog done", q, 16'h0000);

    // R6 store without burst sets BUER
    store(16'h0000, 16'h0001);
    get_stat(2'd0, q); chk("R6 buer", q, 16'h0083);
    pulse_done(1'b0);
    wr(16'hAAAA, 16'h00F5);
    get_stat(2'd0, q); chk("R3 buer cleared", q, 16'h0000);

    // R7 sector erase, R10 erased flag
    erase_seq(16'h8123);
    chk("R7 erase start", {15'b0, erase_start}, 16'h0001);
    chk("R7 erase sector", {14'b0, erase_sec}, 16'h0002);
    get_stat(2'd2, q); chk("R7 erasing", q, 16'h0005);
    pulse_done(1'b1);
    get_stat(2'd2, q); chk("R10 erased set", q, 16'h8000);
    get_stat(2'd1, q); chk("R10 other sector", q, 16'h0000);
    wr(16'hAAAA, 16'h0050); wr(16'h8000, 16'h0A0A);
    store(16'h8000, 16'h0B0B);
    get_stat(2'd2, q); chk("R10 program clears", q, 16'h0003);
    pulse_done(1'b0);
    get_stat(2'd2, q); chk("R10 after prog", q, 16'h0000);

    // R8 erase sequence broken at each step
    @(negedge clk); e0 = n_erase;
    for (int s = 0; s < 6; s++) begin
      logic [15:0] aa [6];
      logic [15:0] dd [6];
      aa = '{16'hAAAA, 16'h5554, 16'hAAAA, 16'h5554, 16'hAAAA, 16'h4000};
      dd = '{16'h00AA, 16'h0055, 16'h0080, 16'h00AA, 16'h0055, 16'h0030};
      wr(16'hAAAA, 16'h00F0);
      for (int i = 0; i <= s; i++)
        if (i < s) wr(aa[i], dd[i]);
        else if (i < 5) wr(16'h1234, dd[i]);
        else wr(aa[i], 16'h0031);
      get_stat(2'd1, q); chk($sformatf("R8 erase broken step %0d", s), q, 16'h0040);
    end
    @(negedge clk);
    chk("R8 no erase started", 16'(n_erase - e0), 16'h0000);

    // R9 stuck busy cleared only by reset
    wr(16'hAAAA, 16'h00F0);
    erase_seq(16'hC000);
    wr(16'hAAAA, 16'h00F0);
    get_stat(2'd3, q); chk("R9 erase busy", q, 16'h0005);
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk); rst_ni = 1'b1;
    get_stat(2'd3, q); chk("R1 R9 reset clears busy", q, 16'h0000);
    chk("R6 R7 start counts", 16'(n_prog * 16 + n_erase), 16'h0032);

    finish_run();
  end
endmodule